// File: doc/BRIEF.md
# CAN mode acknowledge controller

This block holds the operating mode of a CAN protocol core (normal, initialization or sleep) and reports it to software through two acknowledge flags. Software drives two request levels. A request for initialization or sleep is acknowledged on the next clock. When a request is withdrawn, the core must first resynchronise to the bus, so the acknowledge stays set until a run of consecutive recessive bits has been sampled on the receive line. Each sample is qualified by a bit-time strobe.

The block also holds a sticky error interrupt flag. A rising edge on any error status bit sets the flag when the per-source enable for that bit is active. Only a software clear pulse resets the flag. A separate enable gates the flag onto the status-change interrupt output. Bit timing, frame handling and the error counters are outside this block.

Top module: `can_mode_ack`

## Requirements
- R1: After reset the block is in sleep mode: `sleep_ack`=1, `init_ack`=0, `err_flag`=0 and `sc_irq`=0.
- R2: While `init_req`=1, `init_ack` reads 1 on the clock after the request is seen, and `init_ack` and `sleep_ack` are never both 1.
- R3: From normal mode, `sleep_req`=1 with `init_req`=0 sets `sleep_ack` on the next clock.
- R4: When `init_req` and `sleep_req` are both 1, the initialization request wins: `init_ack`=1 and `sleep_ack`=0.
- R5: After the active request is withdrawn, its acknowledge stays at 1 until SYNC_BITS (default 11) consecutive recessive samples have been taken. A sample is a clock with `bit_tick`=1, and it is recessive when `rx_bit`=1. The acknowledge clears on the clock that takes the last sample of the run, and the block then enters the mode that the requests select.
- R6: A dominant sample (`bit_tick`=1, `rx_bit`=0) restarts the recessive run from zero. Clocks with `bit_tick`=0 do not count, whatever `rx_bit` holds.
- R7: `err_flag` is set on the clock after any bit i of `err_src` rises from 0 to 1 while `err_src_en[i]`=1. A status bit that rises while its enable is 0 has no effect, and neither does a status bit that stays high.
- R8: `err_flag` clears only on a clock where `err_clr`=1. If a new enabled edge arrives on that same clock, the set wins.
- R9: `sc_irq` is 1 exactly when `err_flag`=1 and `err_irq_en`=1.
- R10: From sleep mode, a rise of `init_req` moves the block to initialization on the next clock, without waiting for a recessive run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_req | input | 1 | Software request for initialization mode |
| sleep_req | input | 1 | Software request for sleep mode |
| rx_bit | input | 1 | Sampled receive line, 1 = recessive |
| bit_tick | input | 1 | One-clock strobe per bit time |
| err_src | input | NSRC | Error status bits |
| err_src_en | input | NSRC | Per-source enables for the error flag |
| err_irq_en | input | 1 | Enable of the status-change interrupt |
| err_clr | input | 1 | Software clear pulse for the error flag |
| init_ack | output | 1 | Initialization acknowledge |
| sleep_ack | output | 1 | Sleep acknowledge |
| err_flag | output | 1 | Sticky error interrupt flag |
| sc_irq | output | 1 | Status-change interrupt |

## Verification
The hardest case to reach is a recessive run that breaks just short of the threshold, because the ports give no view of the run length. The bench withdraws the request and supplies k recessive samples for every k from 0 to 10, with non-strobe clocks mixed in. It then inserts one dominant sample and shows that exactly ten further recessive samples still leave the acknowledge set, while the eleventh clears it. The error side is swept over every combination of status pattern, enable mask and interrupt enable. That sweep includes a clear that coincides with an edge and a status level that stays high.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_INIT   = 2'd1,
    MODE_SLEEP  = 2'd2
  } mode_e;
endpackage

// File: rtl/can_rst_sync.sv
module can_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/can_sync_counter.sv
// Counts consecutive recessive bit samples while a mode exit is pending.
module can_sync_counter #(
  parameter int SYNC_BITS = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic bit_tick,
  input  logic rx_bit,
  output logic sync_done
);
  localparam int CNT_W = $clog2(SYNC_BITS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SYNC_BITS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    sync_done = run_en && bit_tick && rx_bit && (cnt_q == LAST);
    cnt_en    = 1'b0;
    cnt_d     = cnt_q;
    if (!run_en) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (bit_tick) begin
      cnt_en = 1'b1;
      if (!rx_bit || sync_done) cnt_d = '0;
      else                      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
  import can_mode_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  init_req,
  input  logic  sleep_req,
  input  logic  sync_done,
  output logic  exit_pending,
  output mode_e mode
);
  mode_e mode_q, mode_d, target;

  always_comb begin
    if (init_req)       target = MODE_INIT;
    else if (sleep_req) target = MODE_SLEEP;
    else                target = MODE_NORMAL;

    exit_pending = (mode_q != MODE_NORMAL) && (target != mode_q) &&
                   (target != MODE_INIT);

    mode_d = mode_q;
    if (mode_q == MODE_NORMAL)  mode_d = target;
    else if (target == mode_q)  mode_d = mode_q;
    else if (target == MODE_INIT) mode_d = MODE_INIT;
    else if (sync_done)         mode_d = target;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_SLEEP;
    else        mode_q <= mode_d;
  end

  assign mode = mode_q;
endmodule

// File: rtl/can_err_latch.sv
module can_err_latch #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] err_src,
  input  logic [NSRC-1:0] err_src_en,
  input  logic            err_clr,
  output logic            err_flag
);
  logic [NSRC-1:0] src_q;
  logic [NSRC-1:0] hit;
  logic            flag_q, flag_d, any_hit;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign hit[i] = err_src[i] && !src_q[i] && err_src_en[i];
  end

  always_comb begin
    any_hit = |hit;
    if (any_hit)      flag_d = 1'b1;
    else if (err_clr) flag_d = 1'b0;
    else              flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      src_q  <= err_src;
      flag_q <= flag_d;
    end
  end

  assign err_flag = flag_q;
endmodule

// File: rtl/can_mode_ack.sv
module can_mode_ack
  import can_mode_pkg::*;
#(
  parameter int SYNC_BITS = 11,
  parameter int NSRC      = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            init_req,
  input  logic            sleep_req,
  input  logic            rx_bit,
  input  logic            bit_tick,
  input  logic [NSRC-1:0] err_src,
  input  logic [NSRC-1:0] err_src_en,
  input  logic            err_irq_en,
  input  logic            err_clr,
  output logic            init_ack,
  output logic            sleep_ack,
  output logic            err_flag,
  output logic            sc_irq
);
  logic  rst_core_n;
  logic  exit_pending, sync_done;
  mode_e mode;

  can_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  can_sync_counter #(.SYNC_BITS(SYNC_BITS)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .run_en    (exit_pending),
    .bit_tick  (bit_tick),
    .rx_bit    (rx_bit),
    .sync_done (sync_done)
  );

  can_mode_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .init_req     (init_req),
    .sleep_req    (sleep_req),
    .sync_done    (sync_done),
    .exit_pending (exit_pending),
    .mode         (mode)
  );

  can_err_latch #(.NSRC(NSRC)) u_err (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .err_src    (err_src),
    .err_src_en (err_src_en),
    .err_clr    (err_clr),
    .err_flag   (err_flag)
  );

  assign init_ack  = (mode == MODE_INIT);
  assign sleep_ack = (mode == MODE_SLEEP);
  assign sc_irq    = err_flag & err_irq_en;
endmodule

// File: rtl/can_mode_ack_chk.sv
module can_mode_ack_chk #(
  parameter int NSRC = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            init_req,
  input logic            sleep_req,
  input logic            rx_bit,
  input logic            bit_tick,
  input logic [NSRC-1:0] err_src,
  input logic [NSRC-1:0] err_src_en,
  input logic            err_irq_en,
  input logic            err_clr,
  input logic            init_ack,
  input logic            sleep_ack,
  input logic            err_flag,
  input logic            sc_irq
);
  assert_acks_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(init_ack && sleep_ack));

  assert_init_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    init_req |=> init_ack);

  assert_init_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (init_req && sleep_req) |=> !sleep_ack);

  assert_sleep_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req && !init_req && !init_ack && !sleep_ack) |=> sleep_ack);

  assert_init_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (init_ack && !(bit_tick && rx_bit)) |=> init_ack);

  assert_sleep_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_ack && !init_req && !(bit_tick && rx_bit)) |=> sleep_ack);

  assert_flag_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> $past(|(err_src & err_src_en)));

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clr) |=> err_flag);

  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !err_irq_en |-> !sc_irq);
endmodule

bind can_mode_ack can_mode_ack_chk #(.NSRC(NSRC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .init_req   (init_req),
  .sleep_req  (sleep_req),
  .rx_bit     (rx_bit),
  .bit_tick   (bit_tick),
  .err_src    (err_src),
  .err_src_en (err_src_en),
  .err_irq_en (err_irq_en),
  .err_clr    (err_clr),
  .init_ack   (init_ack),
  .sleep_ack  (sleep_ack),
  .err_flag   (err_flag),
  .sc_irq     (sc_irq)
);

// File: tb/sim_can_mode_ack.sv
module sim_can_mode_ack;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 3;
  localparam int SYNC = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init_req = 1'b0, sleep_req = 1'b0, rx_bit = 1'b1, bit_tick = 1'b0;
  logic [NSRC-1:0] err_src = '0, err_src_en = '0;
  logic err_irq_en = 1'b0, err_clr = 1'b0;
  logic init_ack, sleep_ack, err_flag, sc_irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_mode_ack #(.SYNC_BITS(SYNC), .NSRC(NSRC)) u0 (
    .clk(clk), .rst_n(rst_n), .init_req(init_req), .sleep_req(sleep_req),
    .rx_bit(rx_bit), .bit_tick(bit_tick), .err_src(err_src),
    .err_src_en(err_src_en), .err_irq_en(err_irq_en), .err_clr(err_clr),
    .init_ack(init_ack), .sleep_ack(sleep_ack), .err_flag(err_flag),
    .sc_irq(sc_irq)
  );

  task automatic chk(input logic got, input logic exp, input string what);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", what, got, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic sample(input logic rx);
    @(negedge clk); bit_tick = 1'b1; rx_bit = rx;
    @(negedge clk); bit_tick = 1'b0; rx_bit = 1'b1;
  endtask

  task automatic idle_rx(input logic rx);
    @(negedge clk); bit_tick = 1'b0; rx_bit = rx;
  endtask

  task automatic exit_to_normal();
    @(negedge clk); init_req = 1'b0; sleep_req = 1'b0;
    for (int i = 0; i < SYNC; i++) sample(1'b1);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();
    // R1 reset state
    chk(sleep_ack, 1'b1, "R1 sleep_ack");
    chk(init_ack,  1'b0, "R1 init_ack");
    chk(err_flag,  1'b0, "R1 err_flag");
    chk(sc_irq,    1'b0, "R1 sc_irq");

    // R5/R6 sweep: broken runs of every length below the threshold
    for (int k = 0; k < SYNC; k++) begin
      @(negedge clk); sleep_req = 1'b1;
      step();
      chk(sleep_ack, 1'b1, "R3 sleep entry");
      @(negedge clk); sleep_req = 1'b0;
      for (int j = 0; j < k; j++) begin
        sample(1'b1);
        idle_rx(1'b1);  // R6 non-strobe clocks do not count
        idle_rx(1'b0);
      end
      chk(sleep_ack, 1'b1, "R5 held during partial run");
      sample(1'b0);
      chk(sleep_ack, 1'b1, "R6 held after dominant");
      for (int j = 0; j < SYNC - 1; j++) sample(1'b1);
      chk(sleep_ack, 1'b1, "R6 run restarted by dominant");
      sample(1'b1);
      chk(sleep_ack, 1'b0, "R5 sleep exit after full run");
      chk(init_ack,  1'b0, "R5 normal mode after exit");
    end

    // R2 init entry and exit
    @(negedge clk); init_req = 1'b1;
    step();
    chk(init_ack,  1'b1, "R2 init entry");
    chk(sleep_ack, 1'b0, "R2 exclusive");
    @(negedge clk); init_req = 1'b0;
    for (int j = 0; j < SYNC - 1; j++) sample(1'b1);
    chk(init_ack, 1'b1, "R5 init held one short");
    sample(1'b1);
    chk(init_ack, 1'b0, "R5 init exit");

    // R4 precedence, then init -> sleep through a run
    @(negedge clk); init_req = 1'b1; sleep_req = 1'b1;
    step();
    chk(init_ack,  1'b1, "R4 init wins");
    chk(sleep_ack, 1'b0, "R4 sleep suppressed");
    @(negedge clk); init_req = 1'b0;
    for (int j = 0; j < SYNC - 1; j++) sample(1'b1);
    chk(init_ack,  1'b1, "R5 init held before sleep");
    chk(sleep_ack, 1'b0, "R5 no early sleep");
    sample(1'b1);
    chk(sleep_ack, 1'b1, "R5 sleep after run");
    chk(init_ack,  1'b0, "R5 init cleared");

    // R10 sleep -> init immediate
    @(negedge clk); init_req = 1'b1;
    step();
    chk(init_ack,  1'b1, "R10 sleep to init");
    chk(sleep_ack, 1'b0, "R10 sleep cleared");
    exit_to_normal();
    chk(init_ack, 1'b0, "R5 back to normal");

    // R7/R8/R9 exhaustive sweep
    for (int s = 0; s < (1 << NSRC); s++) begin
      for (int e = 0; e < (1 << NSRC); e++) begin
        for (int q = 0; q < 2; q++) begin
          logic exp;
          exp = |(NSRC'(s) & NSRC'(e));
          @(negedge clk); err_src = '0; err_src_en = NSRC'(e);
          err_irq_en = q[0]; err_clr = 1'b1;
          @(negedge clk); err_clr = 1'b0;
          chk(err_flag, 1'b0, "R8 cleared");
          @(negedge clk); err_src = NSRC'(s);
          step();
          chk(err_flag, exp, "R7 edge sets flag");
          chk(sc_irq, exp & q[0], "R9 irq gate");
          step();
          chk(err_flag, exp, "R7 level holds, no change");
          @(negedge clk); err_src = '0;
          step();
          chk(err_flag, exp, "R8 sticky");
          // clear with a level held high: no re-set
          @(negedge clk); err_src = NSRC'(s); err_clr = 1'b0;
          @(negedge clk); err_clr = 1'b1;
          @(negedge clk); err_clr = 1'b0;
          step();
          chk(err_flag, 1'b0, "R7 held level ignored after clear");
          // simultaneous edge and clear: set wins
          @(negedge clk); err_src = '0;
          @(negedge clk); err_src = NSRC'(s); err_clr = 1'b1;
          @(negedge clk); err_clr = 1'b0;
          chk(err_flag, exp, "R8 set beats clear");
          chk(sc_irq, exp & q[0], "R9 irq after collision");
        end
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule